// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block holds two identical, independent down-counting timers behind a plain 32-bit word-addressed register bus. Each timer has a prescaler in front of it that divides the clock by 1, 16 or 256. It counts down from a programmed start value. When it reaches zero, it either wraps to the all-ones value, reloads a stored period or stops at zero, depending on its control word.

Each timer raises a level interrupt that stays set until software clears it. A single OR-ed line summarises both timers. A reload value can be staged without disturbing the count in progress: it takes effect only at the next reload. Read-only identification bytes sit at the top of the 4 KB register window.

Top module: `dual_down_timer`

## Requirements
- R1: After reset each timer reads a count of 0xFFFFFFFF, a reload value of 0, a control word of 0x02 (32-bit, free-running, disabled) and a raw status of 0, and every interrupt output is low.
- R2: Within each 32-byte timer block the word offsets are 0x00 reload value with restart, 0x04 live count (read-only, writes ignored), 0x08 control, 0x0C interrupt clear (reads 0), 0x10 raw status (bit 0), 0x14 masked status (bit 0) and 0x18 staged reload. Timer 0 starts at 0x00 and timer 1 at 0x20. Accessing one timer never alters the other.
- R3: Control bits are: bit 7 run, bit 6 periodic (0 = free-running), bit 5 interrupt enable, bits 3:2 prescale select, bit 1 32-bit size (0 = 16-bit), bit 0 one-shot. The register reads back what was written in those bits.
- R4: Prescale select 0 gives a count step on every enabled clock. Select 1 gives one step every 16 enabled clocks, and selects 2 and 3 give one every 256. The prescaler restarts from zero whenever the timer is stopped or the offset 0x00 register is written.
- R5: While run is set, each count step lowers the count by one. While run is clear, the count holds its value.
- R6: A write to offset 0x00 stores the reload value. It also restarts the count from the written value, masked to 16 bits when the 16-bit size is selected.
- R7: A write to offset 0x18 stores the reload value without changing the live count. Both reload offsets read back the stored value.
- R8: A step that takes the count from 1 to 0 sets the raw status. A step taken at zero does one of three things: in one-shot mode (which overrides periodic) it holds at zero; in periodic mode it loads the reload value; in free-running mode it loads the all-ones value of the selected size.
- R9: In 16-bit size the count uses only its low 16 bits, so a free-running count wraps from 0 to 0x0000FFFF.
- R10: Any write to offset 0x0C clears that timer's raw status. A status being set in the same cycle takes priority.
- R11: Masked status is the raw status ANDed with interrupt enable. Each timer's interrupt output equals its masked status, and the combined output is high when either is high.
- R12: Offsets 0xFE0 to 0xFEC return the four peripheral identification bytes, and 0xFF0 to 0xFFC the four cell identification bytes, least significant byte first, each in bits 7:0. Any other unmapped offset reads 0.
- R13: Read data is registered and shows the register addressed in the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_ch | output | 2 | Per-timer level interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
The bench builds the block with its default parameters: two timers, a 32-bit bus, an 8-bit prescaler with taps at 16 and 256, and a 12-bit address. Under these values all four prescale selects can be swept over a few hundred clocks. The 16-bit size mode brings the wrap from 0 to 0xFFFF within a handful of steps, and the same holds for the full 32-bit wrap when the count starts at 1. Each expected count is derived from the number of enabled clock edges and the division ratio.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // word index inside one timer block
  localparam logic [2:0] IDX_LOAD  = 3'd0;
  localparam logic [2:0] IDX_VALUE = 3'd1;
  localparam logic [2:0] IDX_CTRL  = 3'd2;
  localparam logic [2:0] IDX_CLR   = 3'd3;
  localparam logic [2:0] IDX_RAW   = 3'd4;
  localparam logic [2:0] IDX_MSK   = 3'd5;
  localparam logic [2:0] IDX_BG    = 3'd6;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       ien;
    logic [1:0] psel;
    logic       wide;
    logic       oneshot;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, ien: 1'b0,
                                       psel: 2'd0, wide: 1'b1, oneshot: 1'b0};

  function automatic tmr_ctrl_t ctrl_unpack(input logic [7:0] w);
    tmr_ctrl_t c;
    c.run      = w[7];
    c.periodic = w[6];
    c.ien      = w[5];
    c.psel     = w[3:2];
    c.wide     = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_pack(input tmr_ctrl_t c);
    return {c.run, c.periodic, c.ien, 1'b0, c.psel, c.wide, c.oneshot};
  endfunction

endpackage

// File: rtl/dt_prescale.sv
module dt_prescale #(
  parameter int PRE_W    = 8,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic             mid_hit, hi_hit;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assign mid_hit = &pre_q[MID_LOG2-1:0];
  assign hi_hit  = &pre_q[HI_LOG2-1:0];

  always_comb begin
    unique case (sel)
      2'd0:    tick = run && !restart;
      2'd1:    tick = run && !restart && mid_hit;
      default: tick = run && !restart && hi_hit;
    endcase
  end

  // R4
  divided_no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != 2'd0) |=> !tick);

endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 8,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] load_o,
  output logic [7:0]        ctrl_o,
  output logic              raw_o,
  output logic              msk_o
);

  localparam int HI_PAD = DATA_W - 16;

  tmr_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] cnt_q, cnt_n, load_q, size_mask, cur;
  logic              raw_q, tick, hit;
  logic              ld_we, bg_we, ctl_we, clr_we;

  assign ld_we  = wr_en && (wr_idx == IDX_LOAD);
  assign bg_we  = wr_en && (wr_idx == IDX_BG);
  assign ctl_we = wr_en && (wr_idx == IDX_CTRL);
  assign clr_we = wr_en && (wr_idx == IDX_CLR);

  dt_prescale #(.PRE_W(PRE_W), .MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .restart (ld_we),
    .sel     (ctrl_q.psel),
    .tick    (tick)
  );

  assign size_mask = {{HI_PAD{ctrl_q.wide}}, 16'hFFFF};
  assign cur       = cnt_q & size_mask;
  assign hit       = tick && !ld_we && (cur == DATA_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (ld_we)                cnt_n = wr_data & size_mask;
    else if (tick) begin
      if (cur != '0)          cnt_n = cur - DATA_W'(1);
      else if (ctrl_q.oneshot) cnt_n = cur;
      else if (ctrl_q.periodic) cnt_n = load_q & size_mask;
      else                    cnt_n = size_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      load_q <= '0;
      ctrl_q <= CTRL_RESET;
      raw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (ld_we || bg_we) load_q <= wr_data;
      if (ctl_we)         ctrl_q <= ctrl_unpack(wr_data[7:0]);
      if (hit)            raw_q  <= 1'b1;
      else if (clr_we)    raw_q  <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign ctrl_o = ctrl_pack(ctrl_q);
  assign raw_o  = raw_q;
  assign msk_o  = raw_q && ctrl_q.ien;

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !ld_we) |=> (cnt_q == $past(cnt_q)));

  // R8
  oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.oneshot && !ctl_we && !ld_we && cur == '0) |=> (cnt_q == $past(cnt_q)));

  // R8
  raw_rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q) |-> ((cnt_q & size_mask) == '0));

  // R10
  clear_drops_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !tick) |=> !raw_q);

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dt_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 12,
  parameter int          NUM_TMR   = 2,
  parameter int          PRE_W     = 8,
  parameter int          MID_LOG2  = 4,
  parameter int          HI_LOG2   = 8,
  parameter logic [31:0] PERIPH_ID = 32'h0051_C0DE,
  parameter logic [31:0] CELL_ID   = 32'hB105_F00D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_TMR-1:0] irq_ch,
  output logic              irq_any
);

  localparam int SEL_W = ADDR_W - 5;

  logic [SEL_W-1:0]  blk;
  logic [2:0]        idx;
  logic [DATA_W-1:0] rd_ch [NUM_TMR];
  logic [DATA_W-1:0] rd_n, rdata_q;
  logic [7:0]        id_byte;

  assign blk = bus_addr[ADDR_W-1:5];
  assign idx = bus_addr[4:2];

  for (genvar c = 0; c < NUM_TMR; c++) begin : g_tmr
    logic [DATA_W-1:0] cnt, load;
    logic [7:0]        ctrl;
    logic              raw, msk;

    dt_channel #(.DATA_W(DATA_W), .PRE_W(PRE_W), .MID_LOG2(MID_LOG2),
                 .HI_LOG2(HI_LOG2)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_we && (blk == SEL_W'(c))),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .cnt_o   (cnt),
      .load_o  (load),
      .ctrl_o  (ctrl),
      .raw_o   (raw),
      .msk_o   (msk)
    );

    always_comb begin
      unique case (idx)
        IDX_LOAD, IDX_BG: rd_ch[c] = load;
        IDX_VALUE:        rd_ch[c] = cnt;
        IDX_CTRL:         rd_ch[c] = DATA_W'(ctrl);
        IDX_RAW:          rd_ch[c] = DATA_W'(raw);
        IDX_MSK:          rd_ch[c] = DATA_W'(msk);
        default:          rd_ch[c] = '0;
      endcase
    end

    assign irq_ch[c] = msk;
  end

  assign id_byte = idx[2] ? CELL_ID[idx[1:0]*8 +: 8] : PERIPH_ID[idx[1:0]*8 +: 8];

  always_comb begin
    rd_n = '0;
    for (int c = 0; c < NUM_TMR; c++)
      if (blk == SEL_W'(c)) rd_n = rd_ch[c];
    if (blk == '1) rd_n = DATA_W'(id_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_n;
  end

  assign bus_rdata = rdata_q;
  assign irq_any   = |irq_ch;

  // R12
  first_id_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (blk == '1 && idx == 3'd0) |=> (bus_rdata == DATA_W'(PERIPH_ID[7:0])));

  // R11
  combined_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ch != '0) |-> irq_any);

endmodule

// File: tb/dual_down_timer_bench.sv
`timescale 1ns/1ps
module dual_down_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_ch;
  logic        irq_any;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PID = 32'h0051_C0DE;
  localparam logic [31:0] CID = 32'hB105_F00D;

  always #2 clk = ~clk;

  dual_down_timer u_dual_down_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(12'h004, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R1 ctrl", v, 32'h02);
    rd(12'h000, v); chk("R1 reload", v, 32'h0);
    rd(12'h010, v); chk("R1 raw", v, 32'h0);
    rd(12'h024, v); chk("R1 count t1", v, 32'hFFFF_FFFF);
    chk("R1 irq", {29'd0, irq_any, irq_ch}, 32'h0);

    // R12 identification bytes, R13 registered read
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), v);
      chk("R12 id", v, {24'd0, (i < 4) ? PID[i*8 +: 8] : CID[(i-4)*8 +: 8]});
    end
    rd(12'h01C, v); chk("R12 unmapped", v, 32'h0);
    rd(12'h800, v); chk("R12 unmapped far", v, 32'h0);

    // R4 R5 prescale sweep: 600 enabled edges
    for (int s = 0; s < 4; s++) begin
      int dv;
      dv = (s == 0) ? 1 : (s == 1) ? 16 : 256;
      wr(12'h000, 32'd1000);
      wr(12'h008, 32'hC2 | (s << 2));
      idle(599);
      wr(12'h008, 32'h02);
      rd(12'h004, v); chk("R4 prescale", v, 32'(1000 - 600 / dv));
    end

    // R3 control readback
    wr(12'h008, 32'h2E);
    rd(12'h008, v); chk("R3 ctrl readback", v, 32'h2E);
    wr(12'h008, 32'h02);

    // R8 R11 periodic reload with interrupt
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE2);
    idle(5);
    chk("R11 irq on zero", {30'd0, irq_any, irq_ch[0]}, 32'h3);
    idle(1);
    wr(12'h008, 32'h62);
    rd(12'h004, v); chk("R8 periodic reload", v, 32'd4);
    rd(12'h010, v); chk("R8 raw set", v, 32'd1);
    wr(12'h00C, 32'h0);
    rd(12'h010, v); chk("R10 clear", v, 32'd0);
    chk("R10 irq low", {30'd0, irq_any, irq_ch[0]}, 32'h0);

    // R8 one-shot parks at zero (overrides periodic)
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE3);
    idle(10);
    wr(12'h008, 32'h63);
    rd(12'h004, v); chk("R8 oneshot hold", v, 32'd0);
    rd(12'h010, v); chk("R8 oneshot raw", v, 32'd1);
    wr(12'h00C, 32'h0);

    // R9 16-bit free-running wrap, R11 masked low when disabled
    wr(12'h008, 32'h00);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h80);
    idle(3);
    wr(12'h008, 32'h00);
    rd(12'h004, v); chk("R9 16-bit wrap", v, 32'h0000_FFFE);
    rd(12'h010, v); chk("R11 raw", v, 32'd1);
    rd(12'h014, v); chk("R11 masked off", v, 32'd0);
    chk("R11 irq masked", {30'd0, irq_any, irq_ch[0]}, 32'h0);
    wr(12'h00C, 32'h0);

    // R6 load masked in 16-bit size
    wr(12'h000, 32'h0001_0005);
    rd(12'h004, v); chk("R6 masked start", v, 32'h5);
    rd(12'h000, v); chk("R6 reload stored", v, 32'h0001_0005);

    // R8 32-bit free-running wrap
    wr(12'h008, 32'h02);
    wr(12'h000, 32'd1);
    wr(12'h008, 32'h82);
    idle(2);
    wr(12'h008, 32'h02);
    rd(12'h004, v); chk("R8 32-bit wrap", v, 32'hFFFF_FFFE);
    wr(12'h00C, 32'h0);

    // R7 staged reload
    wr(12'h000, 32'd20);
    wr(12'h018, 32'd7);
    rd(12'h004, v); chk("R7 count untouched", v, 32'd20);
    rd(12'h018, v); chk("R7 staged readback", v, 32'd7);
    wr(12'h008, 32'hC2);
    idle(20);
    wr(12'h008, 32'h42);
    rd(12'h004, v); chk("R7 staged used", v, 32'd7);
    wr(12'h00C, 32'h0);

    // R5 hold while stopped
    idle(50);
    rd(12'h004, v); chk("R5 stopped hold", v, 32'd7);

    // R2 count is read-only
    wr(12'h004, 32'h1234);
    rd(12'h004, v); chk("R2 value write ignored", v, 32'd7);

    // R2 second timer independent
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hA3);
    idle(2);
    chk("R2 t1 irq only", {30'd0, irq_ch}, 32'h2);
    chk("R11 combined", {31'd0, irq_any}, 32'h1);
    rd(12'h028, v); chk("R2 t1 ctrl", v, 32'hA3);
    rd(12'h034, v); chk("R2 t1 masked", v, 32'd1);
    rd(12'h004, v); chk("R2 t0 untouched", v, 32'd7);
    rd(12'h010, v); chk("R2 t0 raw clear", v, 32'd0);
    wr(12'h02C, 32'h0);
    rd(12'h030, v); chk("R10 t1 clear", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule